// File: doc/BRIEF.md
# Open-Row SDRAM Command Sequencer

This block sits between a simple request stream and an SDRAM command bus. Each accepted request carries an address and a read/write flag. The block splits the address into a bank field, a row field and a column field. It keeps a record of the open row in every bank, and it emits the shortest legal command sequence for the request. A row hit sends only the column command. A bank with no open row first receives an ACTIVATE. A bank that holds a different row first receives a PRECHARGE, then an ACTIVATE, then the column command.

Every column command starts a fixed burst. During the burst a data strobe marks the data phase, and no further address is sent. The block handles one request at a time, in arrival order. A power-down input parks the sequencer. While it is parked, no command is issued. When the input drops, the block waits a fixed wake-up interval before it accepts work again. The open rows are kept through power-down. A classification output reports, for each request, which of the three cases applied.

Top module: `sdram_bank_seq`

## Requirements
- R1: The request address is split, from most to least significant bit, into bank (3 bits), row (14 bits) and column (10 bits). An ACTIVATE presents that bank and row on `cmd_bank`/`cmd_addr`. A READ or WRITE presents that bank and the column, zero-extended, on the same outputs.
- R2: After reset, `cmd` is NOP (code 0), `data_strobe` is low, `req_ready` is high, and every bank is closed. The first access to any bank is therefore treated as a closed-bank access.
- R3: A request to the row already open in its bank issues READ (code 3) or WRITE (code 4) in the first cycle after acceptance, with no ACTIVATE or PRECHARGE.
- R4: A request to a closed bank issues ACTIVATE (code 1) in the first cycle after acceptance. The column command follows exactly T_RCD cycles later (default 3).
- R5: A request to a bank holding a different row issues PRECHARGE (code 2) in the first cycle after acceptance. ACTIVATE follows T_RP cycles later (default 3), and the column command follows T_RCD cycles after that. Open rows in the other banks are unchanged.
- R6: Every cycle in which a command other than NOP is issued is followed by a NOP cycle.
- R7: `data_strobe` is high for exactly 8 consecutive cycles. These start in the cycle after the READ or WRITE.
- R8: `req_ready` is high only when the sequencer is idle and `pd_req` is low. After a column command, it returns high in the cycle after the last strobe cycle.
- R9: While `pd_req` is high, or during the wake-up interval, `cmd` stays NOP, `req_ready` stays low and requests are ignored. `req_ready` rises WAKE_CYC cycles (default 200) after the first clock edge that samples `pd_req` low.
- R10: `class_code` is valid for one cycle, in the cycle of the first command of each request. It reads 1 for a row hit, 2 for a closed bank and 3 for a row conflict, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 27 | Bank, row, column address |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| pd_req | input | 1 | Power-down request |
| asleep | output | 1 | High while powered down or waking |
| cmd | output | 3 | Command code: 0 NOP, 1 ACTIVATE, 2 PRECHARGE, 3 READ, 4 WRITE |
| cmd_bank | output | 3 | Bank of the current command |
| cmd_addr | output | 14 | Row (ACTIVATE) or column (READ/WRITE), else 0 |
| data_strobe | output | 1 | Data phase of a burst |
| class_code | output | 2 | Request class: 1 hit, 2 closed, 3 conflict |

## Verification
A corrupted open-row record shows up in the first command cycle of the next request to that bank. The class code and the leading command then disagree with a bank model that tracks rows independently, so each fault is seen within one request. A wrong wait count shifts the ACTIVATE or the column command by a cycle. A wrong burst count changes the strobe length or the cycle in which ready returns, and the bench compares the whole command and strobe trace of each request cycle by cycle. A wrong wake-up count shows as a ready edge that is off by one or more cycles from the expected interval.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    CLS_NONE     = 2'd0,
    CLS_HIT      = 2'd1,
    CLS_CLOSED   = 2'd2,
    CLS_CONFLICT = 2'd3
  } cls_e;
endpackage

// File: rtl/sbs_row_table.sv
module sbs_row_table #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  localparam int BANKS = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] look_bank,
  input  logic [ROW_W-1:0]  look_row,
  output logic              look_open,
  output logic              look_match,
  input  logic              act_en,
  input  logic [BANK_W-1:0] act_bank,
  input  logic [ROW_W-1:0]  act_row,
  input  logic              pre_en,
  input  logic [BANK_W-1:0] pre_bank,
  output logic [BANKS-1:0]  bank_open
);
  logic [ROW_W-1:0] rows [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic set_b, clr_b, vld_d;
    logic [ROW_W-1:0] row_d;

    always_comb begin
      set_b = act_en && (act_bank == BANK_W'(b));
      clr_b = pre_en && (pre_bank == BANK_W'(b));
      vld_d = set_b ? 1'b1 : (clr_b ? 1'b0 : bank_open[b]);
      row_d = set_b ? act_row : rows[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_open[b] <= 1'b0;
        rows[b]      <= '0;
      end else begin
        bank_open[b] <= vld_d;
        if (set_b) rows[b] <= row_d;
      end
    end
  end

  always_comb begin
    look_open  = bank_open[look_bank];
    look_match = look_open && (rows[look_bank] == look_row);
  end

  assert_act_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_en |=> bank_open[$past(act_bank)]);
  assert_pre_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en && !act_en) |=> !bank_open[$past(pre_bank)]);
endmodule

// File: rtl/sbs_timer.sv
module sbs_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)            cnt_d = load_val;
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
    else                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_bank_seq.sv
module sdram_bank_seq
  import sbs_pkg::*;
#(
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 3,
  parameter int BURST_LEN = 8,
  parameter int WAKE_CYC  = 200,
  localparam int ADDR_W   = BANK_W + ROW_W + COL_W,
  localparam int CA_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  input  logic              pd_req,
  output logic              asleep,
  output logic [2:0]        cmd,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [CA_W-1:0]   cmd_addr,
  output logic              data_strobe,
  output logic [1:0]        class_code
);
  localparam int BANKS = 1 << BANK_W;
  localparam int CNT_W = $clog2(WAKE_CYC + BURST_LEN + T_RP + T_RCD);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_TRP, S_ACT, S_TRCD, S_COL, S_BURST, S_PD, S_WAKE
  } state_e;

  state_e            st_q, st_d;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              wr_q;
  cls_e              cls_q, cls_d;
  logic [BANK_W-1:0] in_bank;
  logic [ROW_W-1:0]  in_row;
  logic [COL_W-1:0]  in_col;
  logic              look_open, look_match, accept;
  logic [BANKS-1:0]  bank_open;
  logic              tm_load, tm_zero;
  logic [CNT_W-1:0]  tm_val;
  cmd_e              cmd_c;

  assign in_bank = req_addr[ADDR_W-1 -: BANK_W];
  assign in_row  = req_addr[COL_W +: ROW_W];
  assign in_col  = req_addr[COL_W-1:0];
  assign accept  = req_ready && req_valid;

  sbs_row_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n),
    .look_bank(in_bank), .look_row(in_row),
    .look_open(look_open), .look_match(look_match),
    .act_en(st_q == S_ACT), .act_bank(bank_q), .act_row(row_q),
    .pre_en(st_q == S_PRE), .pre_bank(bank_q),
    .bank_open(bank_open)
  );

  sbs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val), .zero(tm_zero)
  );

  // next-state
  always_comb begin
    st_d    = st_q;
    cls_d   = CLS_NONE;
    tm_load = 1'b0;
    tm_val  = '0;
    unique case (st_q)
      S_IDLE:
        if (pd_req) st_d = S_PD;
        else if (req_valid) begin
          if (!look_open) begin
            st_d = S_ACT; cls_d = CLS_CLOSED;
          end else if (look_match) begin
            st_d = S_COL; cls_d = CLS_HIT;
          end else begin
            st_d = S_PRE; cls_d = CLS_CONFLICT;
          end
        end
      S_PRE:   begin st_d = S_TRP;  tm_load = 1'b1; tm_val = CNT_W'(T_RP - 2);  end
      S_TRP:   if (tm_zero) st_d = S_ACT;
      S_ACT:   begin st_d = S_TRCD; tm_load = 1'b1; tm_val = CNT_W'(T_RCD - 2); end
      S_TRCD:  if (tm_zero) st_d = S_COL;
      S_COL:   begin st_d = S_BURST; tm_load = 1'b1; tm_val = CNT_W'(BURST_LEN - 1); end
      S_BURST: if (tm_zero) st_d = S_IDLE;
      S_PD:
        if (!pd_req) begin
          st_d = S_WAKE; tm_load = 1'b1; tm_val = CNT_W'(WAKE_CYC - 1);
        end
      S_WAKE:  if (tm_zero) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cls_q <= CLS_NONE;
    end else begin
      st_q  <= st_d;
      cls_q <= cls_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      wr_q   <= 1'b0;
    end else if (accept) begin
      bank_q <= in_bank;
      row_q  <= in_row;
      col_q  <= in_col;
      wr_q   <= req_write;
    end
  end

  // outputs
  always_comb begin
    cmd_c    = CMD_NOP;
    cmd_addr = '0;
    unique case (st_q)
      S_PRE: cmd_c = CMD_PRE;
      S_ACT: begin cmd_c = CMD_ACT; cmd_addr = CA_W'(row_q); end
      S_COL: begin cmd_c = wr_q ? CMD_WR : CMD_RD; cmd_addr = CA_W'(col_q); end
      default: cmd_c = CMD_NOP;
    endcase
  end

  assign cmd         = cmd_c;
  assign cmd_bank    = bank_q;
  assign data_strobe = (st_q == S_BURST);
  assign req_ready   = (st_q == S_IDLE) && !pd_req;
  assign asleep      = (st_q == S_PD) || (st_q == S_WAKE);
  assign class_code  = cls_q;

  assert_nop_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_NOP) |=> (cmd == CMD_NOP));
  assert_quiet_asleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (cmd == CMD_NOP) && !req_ready);
  assert_strobe_after_col_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_strobe) |-> ($past(cmd) == CMD_RD || $past(cmd) == CMD_WR));
  assert_class_with_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (class_code != CLS_NONE) |-> (cmd != CMD_NOP));
  assert_ready_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !data_strobe && (cmd == CMD_NOP));
  assert_hit_needs_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (class_code == CLS_HIT) |-> bank_open[cmd_bank]);
endmodule

// File: tb/sdram_bank_seq_test.sv
module sdram_bank_seq_test;
  localparam int TRP = 3, TRCD = 3, BL = 8, WAKE = 200;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, pd_req = 0;
  logic [26:0] req_addr = '0;
  logic req_ready, asleep, data_strobe;
  logic [2:0] cmd;
  logic [2:0] cmd_bank;
  logic [13:0] cmd_addr;
  logic [1:0] class_code;

  int checks = 0, fails = 0;
  bit done = 0;
  bit mv [8];
  int mr [8];

  always #10 clk = ~clk;

  sdram_bank_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(req_ready), .pd_req(pd_req), .asleep(asleep),
    .cmd(cmd), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .data_strobe(data_strobe), .class_code(class_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_class(input int b, input int r);
    if (!mv[b]) return 2;
    if (mr[b] == r) return 1;
    return 3;
  endfunction

  task automatic serve(input int b, input int r, input int c, input bit wr);
    int cls, tpre, tact, tcol, ecmd, eaddr;
    bit seq_ok = 1, addr_ok = 1, strb_ok = 1, rdy_ok = 1;
    int bad_cmd = 0, bad_exp = 0;
    while (!req_ready) @(negedge clk);
    cls = exp_class(b, r);
    tpre = (cls == 3) ? 1 : 0;
    tact = (cls == 2) ? 1 : (cls == 3) ? 1 + TRP : 0;
    tcol = (cls == 1) ? 1 : tact + TRCD;
    req_valid = 1; req_write = wr;
    req_addr = {b[2:0], r[13:0], c[9:0]};
    @(negedge clk);
    req_valid = 0;
    check(class_code == 2'(cls), "R10 class", class_code, cls);
    for (int t = 1; t <= tcol + BL + 1; t++) begin
      if (t > 1) @(negedge clk);
      ecmd = 0; eaddr = 0;
      if (t == tpre) ecmd = 2;
      if (t == tact) begin ecmd = 1; eaddr = r; end
      if (t == tcol) begin ecmd = wr ? 4 : 3; eaddr = c; end
      if (cmd != 3'(ecmd)) begin seq_ok = 0; bad_cmd = cmd; bad_exp = ecmd; end
      if (ecmd != 0 && (cmd_bank != 3'(b) || cmd_addr != 14'(eaddr))) addr_ok = 0;
      if (data_strobe != (t > tcol && t <= tcol + BL)) strb_ok = 0;
      if (req_ready != (t == tcol + BL + 1)) rdy_ok = 0;
    end
    case (cls)
      1: check(seq_ok, "R3 hit sequence", bad_cmd, bad_exp);
      2: check(seq_ok, "R4 closed-bank sequence", bad_cmd, bad_exp);
      default: check(seq_ok, "R5 conflict sequence", bad_cmd, bad_exp);
    endcase
    check(addr_ok, "R1 bank/address fields", addr_ok, 1);
    check(strb_ok, "R7 strobe window", strb_ok, 1);
    check(rdy_ok, "R8 ready return", rdy_ok, 1);
    mv[b] = 1; mr[b] = r;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int s, n, cnt;
    bit quiet;
    s = $urandom(32'd2024);
    for (int i = 0; i < 8; i++) begin mv[i] = 0; mr[i] = 0; end
    repeat (3) @(negedge clk);
    check(cmd == 0 && !data_strobe && class_code == 0, "R2 reset outputs", cmd, 0);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R2 ready after reset", req_ready, 1);

    serve(0, 5, 17, 0);          // R2 first access closed
    serve(0, 5, 18, 1);          // R3 hit write
    serve(7, 16383, 1023, 0);    // R1 extreme fields
    serve(0, 6, 0, 0);           // R5 conflict in bank 0
    serve(7, 16383, 3, 1);       // R5 other bank still open -> hit

    // R9 power-down
    pd_req = 1;
    @(negedge clk);
    check(req_ready == 0 && asleep == 1, "R9 asleep after pd_req", req_ready, 0);
    req_valid = 1; req_addr = {3'd2, 14'd9, 10'd9};
    quiet = 1;
    repeat (10) begin
      @(negedge clk);
      if (cmd != 0 || req_ready) quiet = 0;
    end
    check(quiet, "R9 no command while powered down", quiet, 1);
    req_valid = 0; pd_req = 0;
    cnt = 0; quiet = 1;
    while (!req_ready && cnt < 1000) begin
      @(negedge clk); cnt++;
      if (cmd != 0) quiet = 0;
    end
    check(cnt == WAKE + 1, "R9 wake delay", cnt, WAKE + 1);
    check(quiet, "R9 quiet during wake", quiet, 1);
    serve(7, 16383, 5, 0);       // R9 rows kept, request ignored
    serve(2, 9, 9, 0);           // bank 2 still closed

    n = 0;
    repeat (150) begin
      int b, r, c;
      b = int'($urandom % 8);
      r = ($urandom % 6 == 0) ? 16383 : int'($urandom % 3);
      c = int'($urandom % 1024);
      serve(b, r, c, bit'($urandom % 2));
      n++;
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule